// File: doc/BRIEF.md
# Byte Memory Access Controller

This block sits between a microcoded 8-bit datapath and one byte-wide main memory. Instructions, data and stack all live in that memory, which holds 65536 bytes. The controller keeps five registers: the upper address byte, the lower address byte, the outgoing store byte, the incoming data byte and the instruction byte. It watches two fields of each microinstruction. The first is the 4-bit ALU destination code. The second is the 2-bit memory-sink code, which says which registers take the byte that comes back from memory.

Writing the lower address byte through the destination code starts an access as a side effect. A read or a write always lasts two cycles. The first is the launch cycle, in which the code is presented. The second is the busy cycle, during which the strobe goes to memory. Read data is captured only at the end of the busy cycle. A launch presented during the busy cycle is dropped and sets a sticky error flag.

The sequencer has three states. `ST_IDLE` takes a read code to `ST_RD_WAIT` and a write code to `ST_WR_WAIT`. Both wait states return to `ST_IDLE` unconditionally. Every other code leaves `ST_IDLE` unchanged.

Top module: `mem_access_ctrl`

## Requirements
- R1: After reset, all five registers read 0, `busy`, `mem_rd`, `mem_we`, `rd_done` and `acc_err` are 0, and the state is idle.
- R2: Destination code 4'b1010 loads `alu_bus` into the upper address register, and code 4'b1111 loads it into the store register. Neither starts an access. Both codes are accepted during the busy cycle without raising the error flag.
- R3: Destination code 4'b1011 presented while idle loads `alu_bus` into the lower address register. In the following cycle `mem_rd` and `busy` are both 1 and `mem_addr` equals {upper, new lower}. `busy` is 1 for that one cycle only.
- R4: Destination code 4'b1101 presented while idle loads the lower address register. In the following cycle, and only in that cycle, `mem_we` is 1, `mem_addr` is {upper, lower} as captured at launch, and `mem_wdata` is the store register value at launch.
- R5: At the end of a read's busy cycle, the memory-sink code decides what `mem_rdata` loads. 2'b00 loads nothing. 2'b01 loads the data register. 2'b10 loads the data register and the lower address register. 2'b11 loads those two and the instruction register. `rd_done` is 1 in the cycle after.
- R6: A nonzero memory-sink code presented while idle, or during a write's busy cycle, changes no register.
- R7: A read or write code presented during the busy cycle is ignored. The lower address register keeps its value, no extra strobe follows, and `acc_err` goes to 1 and stays there until reset.
- R8: A new access launched in the cycle right after a completion is accepted without error, so accesses can run every two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dst_sel | input | 4 | ALU destination code of the current microinstruction |
| alu_bus | input | 8 | ALU/shifter result byte |
| mdst_sel | input | 2 | Memory-sink code of the current microinstruction |
| mem_rdata | input | 8 | Byte returned by memory |
| mem_addr | output | 16 | Address of the access in flight |
| mem_wdata | output | 8 | Byte to store |
| mem_rd | output | 1 | Read strobe, busy cycle of a read |
| mem_we | output | 1 | Write strobe, one cycle |
| busy | output | 1 | Second cycle of an access |
| rd_done | output | 1 | Read data captured on the previous edge |
| acc_err | output | 1 | Sticky flag for a launch dropped while busy |
| addr_hi_q | output | 8 | Upper address register |
| addr_lo_q | output | 8 | Lower address register |
| wdata_q | output | 8 | Store register |
| mdr_q | output | 8 | Incoming data register |
| ir_q | output | 8 | Instruction register |

## Verification
The hardest case to reach from the ports is a launch that collides with the busy cycle while a memory-sink code is active in the same cycle. The dropped launch and the legal capture then compete for the lower address register at one edge. The stimulus starts a read and, in the very next cycle, presents a write code, a fresh `alu_bus` value and sink code 2'b10 together. The bench then checks three things: the lower address register holds the memory byte and not the ALU byte, the error flag is set, and no write strobe follows.

// File: rtl/mac_pkg.sv
package mac_pkg;
    localparam logic [3:0] DST_AHI  = 4'b1010;
    localparam logic [3:0] DST_RD   = 4'b1011;
    localparam logic [3:0] DST_WR   = 4'b1101;
    localparam logic [3:0] DST_WDAT = 4'b1111;

    localparam int NSINK = 3; // data reg, lower address, instruction reg

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD_WAIT,
        ST_WR_WAIT
    } mac_state_t;
endpackage

// File: rtl/mac_seq.sv
module mac_seq
    import mac_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [3:0]      dst_sel,
    input  logic [DW-1:0]   alu_bus,
    input  logic [DW-1:0]   addr_hi_q,
    input  logic [DW-1:0]   wdata_q,
    output logic            lo_launch_we,
    output logic            cap_en,
    output logic [2*DW-1:0] mem_addr,
    output logic [DW-1:0]   mem_wdata,
    output logic            mem_rd,
    output logic            mem_we,
    output logic            busy,
    output logic            rd_done,
    output logic            acc_err
);
    localparam int AW = 2 * DW;

    mac_state_t state_q, state_d;
    logic [AW-1:0] addr_lat_q;
    logic [DW-1:0] data_lat_q;
    logic          req_rd, req_wr, req_any;

    assign req_rd  = (dst_sel == DST_RD);
    assign req_wr  = (dst_sel == DST_WR);
    assign req_any = req_rd | req_wr;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_rd)      state_d = ST_RD_WAIT;
                else if (req_wr) state_d = ST_WR_WAIT;
            end
            ST_RD_WAIT: state_d = ST_IDLE;
            ST_WR_WAIT: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        mem_rd       = 1'b0;
        mem_we       = 1'b0;
        busy         = 1'b0;
        cap_en       = 1'b0;
        lo_launch_we = 1'b0;
        unique case (state_q)
            ST_IDLE:    lo_launch_we = req_any;
            ST_RD_WAIT: begin
                mem_rd = 1'b1;
                busy   = 1'b1;
                cap_en = 1'b1;
            end
            ST_WR_WAIT: begin
                mem_we = 1'b1;
                busy   = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_lat_q <= '0;
            data_lat_q <= '0;
            rd_done    <= 1'b0;
            acc_err    <= 1'b0;
        end else begin
            rd_done <= cap_en;
            if (lo_launch_we) begin
                addr_lat_q <= {addr_hi_q, alu_bus};
                data_lat_q <= wdata_q;
            end
            if (busy && req_any) acc_err <= 1'b1;
        end
    end

    assign mem_addr  = addr_lat_q;
    assign mem_wdata = data_lat_q;

    p_busy_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);
    p_read_follows_launch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_rd) |=> (mem_rd && busy));
    p_we_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);
    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |=> acc_err);
    p_err_on_collision_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_any) |=> (acc_err && !busy));
    p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_we));
endmodule

// File: rtl/mac_regs.sv
module mac_regs
    import mac_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    dst_sel,
    input  logic [DW-1:0] alu_bus,
    input  logic [1:0]    mdst_sel,
    input  logic [DW-1:0] mem_rdata,
    input  logic          cap_en,
    input  logic          lo_launch_we,
    output logic [DW-1:0] addr_hi_q,
    output logic [DW-1:0] addr_lo_q,
    output logic [DW-1:0] wdata_q,
    output logic [DW-1:0] mdr_q,
    output logic [DW-1:0] ir_q
);
    // sink g loads when the sink code exceeds g, only at read completion
    logic [NSINK-1:0] sink_ld;

    generate
        for (genvar g = 0; g < NSINK; g++) begin : g_sink
            assign sink_ld[g] = cap_en && (int'(mdst_sel) > g);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_hi_q <= '0;
            addr_lo_q <= '0;
            wdata_q   <= '0;
            mdr_q     <= '0;
            ir_q      <= '0;
        end else begin
            if (dst_sel == DST_AHI)  addr_hi_q <= alu_bus;
            if (dst_sel == DST_WDAT) wdata_q   <= alu_bus;
            if (sink_ld[0]) mdr_q <= mem_rdata;
            if (sink_ld[1])        addr_lo_q <= mem_rdata;
            else if (lo_launch_we) addr_lo_q <= alu_bus;
            if (sink_ld[2]) ir_q <= mem_rdata;
        end
    end

    p_ir_only_on_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> $stable(ir_q));
    p_mdr_only_on_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> $stable(mdr_q));
endmodule

// File: rtl/mem_access_ctrl.sv
module mem_access_ctrl
    import mac_pkg::*;
#(
    parameter int DW = 8,
    localparam int AW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    dst_sel,
    input  logic [DW-1:0] alu_bus,
    input  logic [1:0]    mdst_sel,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_rd,
    output logic          mem_we,
    output logic          busy,
    output logic          rd_done,
    output logic          acc_err,
    output logic [DW-1:0] addr_hi_q,
    output logic [DW-1:0] addr_lo_q,
    output logic [DW-1:0] wdata_q,
    output logic [DW-1:0] mdr_q,
    output logic [DW-1:0] ir_q
);
    logic lo_launch_we, cap_en;

    mac_seq #(.DW(DW)) seq_i (
        .clk(clk), .rst_n(rst_n), .dst_sel(dst_sel), .alu_bus(alu_bus),
        .addr_hi_q(addr_hi_q), .wdata_q(wdata_q),
        .lo_launch_we(lo_launch_we), .cap_en(cap_en),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rd(mem_rd), .mem_we(mem_we), .busy(busy),
        .rd_done(rd_done), .acc_err(acc_err)
    );

    mac_regs #(.DW(DW)) regs_i (
        .clk(clk), .rst_n(rst_n), .dst_sel(dst_sel), .alu_bus(alu_bus),
        .mdst_sel(mdst_sel), .mem_rdata(mem_rdata),
        .cap_en(cap_en), .lo_launch_we(lo_launch_we),
        .addr_hi_q(addr_hi_q), .addr_lo_q(addr_lo_q), .wdata_q(wdata_q),
        .mdr_q(mdr_q), .ir_q(ir_q)
    );

    p_lo_held_on_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_rd && (dst_sel == DST_RD || dst_sel == DST_WR)) |=> $stable(addr_lo_q));
endmodule

// File: tb/mem_access_ctrl_tb_top.sv
module mem_access_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  dst_sel;
    logic [7:0]  alu_bus;
    logic [1:0]  mdst_sel;
    logic [7:0]  mem_rdata;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata, addr_hi_q, addr_lo_q, wdata_q, mdr_q, ir_q;
    logic        mem_rd, mem_we, busy, rd_done, acc_err;

    int checks = 0;
    int errors = 0;

    localparam logic [3:0] C_NONE = 4'b0000, C_AHI = 4'b1010, C_RD = 4'b1011,
                           C_WR = 4'b1101, C_WDAT = 4'b1111;

    // {upper, lower, sink code}
    localparam logic [17:0] VEC [6] = '{
        {8'h12, 8'h34, 2'd1}, {8'h00, 8'h00, 2'd0}, {8'hFF, 8'hFF, 2'd3},
        {8'hA0, 8'h5B, 2'd2}, {8'h7E, 8'h81, 2'd3}, {8'h01, 8'hC2, 2'd1}
    };

    always #2.5 clk = ~clk;

    function automatic logic [7:0] rfn(input logic [15:0] a);
        return a[15:8] ^ {a[3:0], a[7:4]} ^ 8'h3C;
    endfunction

    assign mem_rdata = mem_rd ? rfn(mem_addr) : 8'h00;

    mem_access_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .dst_sel(dst_sel), .alu_bus(alu_bus),
        .mdst_sel(mdst_sel), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_we(mem_we), .busy(busy),
        .rd_done(rd_done), .acc_err(acc_err), .addr_hi_q(addr_hi_q),
        .addr_lo_q(addr_lo_q), .wdata_q(wdata_q), .mdr_q(mdr_q), .ir_q(ir_q)
    );

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic step(input logic [3:0] d, input logic [7:0] a, input logic [1:0] m);
        dst_sel = d; alu_bus = a; mdst_sel = m;
        @(posedge clk); #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step(C_NONE, 8'h00, 2'd0);
        step(C_NONE, 8'h00, 2'd0);
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] e_mdr, e_lo, e_ir, d;
        dst_sel = C_NONE; alu_bus = 0; mdst_sel = 0; rst_n = 1'b0;
        do_reset();
        // R1 reset state
        chk("R1 regs", {addr_hi_q ^ addr_lo_q ^ wdata_q, mdr_q | ir_q}, 16'h0000);
        chk("R1 flags", {11'd0, busy, mem_rd, mem_we, rd_done, acc_err}, 16'h0000);

        // R2 upper address and store register; no access
        step(C_AHI, 8'h5A, 2'd0);
        chk("R2 upper", addr_hi_q, 16'h005A);
        chk("R2 no access", {14'd0, busy, mem_we}, 16'h0000);
        step(C_WDAT, 8'hC3, 2'd0);
        chk("R2 store", wdata_q, 16'h00C3);
        chk("R2 no access", {14'd0, busy, mem_rd}, 16'h0000);

        // R6 sink code while idle loads nothing
        step(C_NONE, 8'h99, 2'd3);
        chk("R6 idle sink", {mdr_q, ir_q}, 16'h0000);
        chk("R6 idle lo", addr_lo_q, 16'h0000);

        // R3/R5 table walk
        e_mdr = 8'h00; e_ir = 8'h00;
        for (int i = 0; i < 6; i++) begin
            logic [7:0] h, l;
            logic [1:0] m;
            {h, l, m} = VEC[i];
            step(C_AHI, h, 2'd0);
            step(C_RD, l, 2'd0);
            chk("R3 strobe", {14'd0, mem_rd, busy}, 16'h0003);
            chk("R3 addr", mem_addr, {h, l});
            chk("R3 lower", addr_lo_q, {8'h00, l});
            step(C_NONE, 8'h00, m);
            d = rfn({h, l});
            if (m >= 2'd1) e_mdr = d;
            e_lo = (m >= 2'd2) ? d : l;
            if (m == 2'd3) e_ir = d;
            chk("R5 data reg", mdr_q, {8'h00, e_mdr});
            chk("R5 lower", addr_lo_q, {8'h00, e_lo});
            chk("R5 instr reg", ir_q, {8'h00, e_ir});
            chk("R5 done/R3 busy", {14'd0, rd_done, busy}, 16'h0002);
        end

        // R4 write, with R6 sink code during the write busy cycle
        step(C_AHI, 8'h12, 2'd0);
        step(C_WDAT, 8'hA5, 2'd0);
        step(C_WR, 8'h34, 2'd0);
        chk("R4 strobe", {14'd0, mem_we, busy}, 16'h0003);
        chk("R4 addr", mem_addr, 16'h1234);
        chk("R4 data", mem_wdata, 16'h00A5);
        // R2 store code accepted during busy
        step(C_WDAT, 8'h66, 2'd3);
        chk("R4 single strobe", {15'd0, mem_we}, 16'h0000);
        chk("R6 write sink", {mdr_q, ir_q}, {e_mdr, e_ir});
        chk("R6 write lo", addr_lo_q, 16'h0034);
        chk("R2 busy store", {wdata_q, 7'd0, acc_err}, 16'h6600);

        // R8 back-to-back: read launched right after completion
        step(C_RD, 8'h40, 2'd0);
        chk("R8 accepted", {14'd0, mem_rd, acc_err}, 16'h0002);
        chk("R8 addr", mem_addr, 16'h1240);
        step(C_WR, 8'h41, 2'd1);
        // that write code was in the busy cycle: dropped (R7)
        d = rfn(16'h1240);
        chk("R8 data", mdr_q, {8'h00, d});
        chk("R7 err", {15'd0, acc_err}, 16'h0001);
        chk("R7 lower kept", addr_lo_q, 16'h0040);
        chk("R7 no strobe", {14'd0, mem_we, busy}, 16'h0000);

        // R7 collision with sink code 10 in same cycle
        step(C_RD, 8'h50, 2'd0);
        step(C_WR, 8'hEE, 2'd2);
        d = rfn(16'h1250);
        chk("R7 lower from memory", addr_lo_q, {8'h00, d});
        chk("R7 no write", {14'd0, mem_we, busy}, 16'h0000);
        step(C_NONE, 8'h00, 2'd0);
        chk("R7 sticky", {15'd0, acc_err}, 16'h0001);

        // R1 reset clears the error
        do_reset();
        chk("R1 err cleared", {15'd0, acc_err}, 16'h0000);
        chk("R1 regs again", {addr_hi_q, mdr_q}, 16'h0000);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule